// File: doc/BRIEF.md
# Dual-Slot Card Status Change Unit

This unit watches the status pins of two removable-card slots and presents them to a host as three 32-bit registers. Each slot owns one 16-bit half of every register. Slot A is in bits 31..16 and slot B is in bits 15..0, so any slot B mask is the slot A mask shifted right by 16. All pins pass through a two-flop synchroniser. The unit reports transitions as sticky change bits, which the host clears by writing ones. A per-bit enable register selects which change bits drive a single level interrupt line. The unit also gives a card-present flag for each slot.

Card detection uses two pins, CD1 and CD2, which reach their final level at different times as a card slides in or out. A four-state machine in each slot follows them:

- DET_EMPTY: both pins high.
- DET_ARRIVING: the pins disagree and the last agreed level was empty.
- DET_LOADED: both pins low.
- DET_LEAVING: the pins disagree and the last agreed level was loaded.

The transitions are:

- Insert: DET_EMPTY or DET_ARRIVING to DET_LOADED. This raises a detect event.
- Remove: DET_LOADED or DET_LEAVING to DET_EMPTY. This raises a detect event.
- Split: DET_EMPTY to DET_ARRIVING, or DET_LOADED to DET_LEAVING.
- Bounce back: DET_ARRIVING to DET_EMPTY, or DET_LEAVING to DET_LOADED. This raises no event.

Bus address 0 is the pin register, 1 is the change register, 2 is the enable register and 3 is a spare address. A write acts only on the slot halves whose strobe bit is set. Strobe bit 0 selects slot A and strobe bit 1 selects slot B. Slot s takes its pins from `card_pins[8s+7:8s]`, ordered from bit 7 down as VS1, VS2, WP, CD2, CD1, BVD2, BVD1, RDY.

Top module: `card_status_unit`

## Requirements
- R1: After reset, with CD1 and CD2 high and the other pins low, the stored change bits and the enable register are zero, `irq` is low and `card_present` is zero.
- R2: A read of address 0 returns the synchronised pins. For slot A, VS1..RDY sit in bits 31..24. For slot B they sit in bits 15..8. The remaining bits of each half read zero.
- R3: VS1 and VS2 form a two-bit field at bit 30 minus 16 times the slot number: bits 31:30 for slot A and bits 15:14 for slot B.
- R4: Any transition on VS1, VS2, WP, BVD2, BVD1 or RDY sets the change bit at the same position as that pin in address 1. The bit holds until it is cleared.
- R5: A write to address 1 clears each bit written as one in a strobed half and leaves the other bits unchanged. A transition that lands in the same cycle as the clear leaves its bit set.
- R6: `card_present[s]` is high only while both detect pins of slot s are low. The two detect change bits (field bits 12 and 11, which are bits 28/27 and 12/11 of the word) set together, and only when the pins reach an agreed level that differs from the last agreed level.
- R7: A rising edge on RDY sets field bit 5 (bits 21/5 of the word). A falling edge sets field bit 4 (bits 20/4). Both are sticky until written as one.
- R8: Field bit 7 (bits 23/7) reads one while RDY is low, and field bit 6 (bits 22/6) reads one while RDY is high. Both are live levels that writes do not change.
- R9: A write to address 2 replaces the strobed halves of the enable register. Address 2 reads back its contents.
- R10: `irq` is high exactly when some bit of the address 1 read value and the same bit of the enable register are both one.
- R11: Writes to addresses 0 and 3 change nothing. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_pins | input | 16 | Raw slot pins, 8 per slot, slot s at bits 8s+7..8s |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wstrb | input | 2 | Per-slot write enable (bit 0 = slot A half, bit 1 = slot B half) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Level interrupt |
| card_present | output | 2 | Card-present flag per slot |

## Verification
The assertions assume that `bus_wr` stays low while reset is active. They also assume that the pins are held at their idle values (detect pins high) across reset, so that the first synchronised sample produces no spurious transition.

The bench follows both assumptions. It changes pins only at falling clock edges and then waits long enough for the synchroniser and the edge register to settle before it checks. The exception is the directed collision case, which times a clear to land in the same cycle as a set.

Random pin patterns cover disagreeing detect pins, so the assertion that ties presence to the earlier synchronised detect levels is exercised on both bounce paths.

// File: rtl/csu_pkg.sv
package csu_pkg;
    // pins per slot and width of one slot's register half
    localparam int PIN_W   = 8;
    localparam int FIELD_W = 16;

    // pin vector bit positions used by logic (order: VS1 VS2 WP CD2 CD1 BVD2 BVD1 RDY)
    localparam int PIN_CD2 = 4;
    localparam int PIN_CD1 = 3;
    localparam int PIN_RDY = 0;

    // field layout: pins occupy the upper byte, ready status below
    localparam int FLD_PIN_LSB  = 8;
    localparam int FLD_RDY_LOW  = 7;
    localparam int FLD_RDY_HIGH = 6;
    localparam int FLD_RDY_RISE = 5;
    localparam int FLD_RDY_FALL = 4;

    // pins whose raw transitions set change bits (detect pins excluded)
    localparam logic [PIN_W-1:0] PIN_TOGGLE_MASK = 8'hE7;
    // idle pin levels: detect pins pulled high, everything else low
    localparam logic [PIN_W-1:0] PIN_IDLE = 8'h18;

    typedef enum logic [1:0] {
        DET_EMPTY    = 2'd0,
        DET_ARRIVING = 2'd1,
        DET_LOADED   = 2'd2,
        DET_LEAVING  = 2'd3
    } det_state_t;

    typedef enum logic [1:0] {
        REG_PINS   = 2'd0,
        REG_CHANGE = 2'd1,
        REG_ENABLE = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/csu_sync.sv
module csu_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/csu_detect_fsm.sv
module csu_detect_fsm
    import csu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cd1,
    input  logic cd2,
    output logic present,
    output logic det_event
);
    det_state_t state_q, state_d;
    logic both_in, both_out;

    assign both_in  = ~cd1 & ~cd2;
    assign both_out =  cd1 &  cd2;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_EMPTY;
        else        state_q <= state_d;
    end

    // transitions; an event fires only on reaching a new agreed level
    always_comb begin
        state_d   = state_q;
        det_event = 1'b0;
        unique case (state_q)
            DET_EMPTY: begin
                if (both_in) begin
                    state_d   = DET_LOADED;
                    det_event = 1'b1;
                end else if (!both_out) begin
                    state_d = DET_ARRIVING;
                end
            end
            DET_ARRIVING: begin
                if (both_in) begin
                    state_d   = DET_LOADED;
                    det_event = 1'b1;
                end else if (both_out) begin
                    state_d = DET_EMPTY;
                end
            end
            DET_LOADED: begin
                if (both_out) begin
                    state_d   = DET_EMPTY;
                    det_event = 1'b1;
                end else if (!both_in) begin
                    state_d = DET_LEAVING;
                end
            end
            DET_LEAVING: begin
                if (both_out) begin
                    state_d   = DET_EMPTY;
                    det_event = 1'b1;
                end else if (both_in) begin
                    state_d = DET_LOADED;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        present = (state_q == DET_LOADED);
    end

    // R6: presence implies both detect pins were low when the state was taken
    a_r6_present_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        present |-> $past(~cd1 & ~cd2));
endmodule

// File: rtl/csu_slot.sv
module csu_slot
    import csu_pkg::*;
#(
    parameter logic [PIN_W-1:0] RST_PINS = PIN_IDLE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_W-1:0]   pins_s,
    input  logic [FIELD_W-1:0] clr,
    input  logic [FIELD_W-1:0] en,
    output logic [FIELD_W-1:0] chg_view,
    output logic               present,
    output logic               irq
);
    // stored bits: pin transitions and the two ready edges
    localparam logic [FIELD_W-1:0] STORE_MASK = 16'hFF30;

    logic [PIN_W-1:0]   pins_prev;
    logic [FIELD_W-1:0] chg_q, set_vec;
    logic               det_event;

    csu_detect_fsm u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd1       (pins_s[PIN_CD1]),
        .cd2       (pins_s[PIN_CD2]),
        .present   (present),
        .det_event (det_event)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_prev <= RST_PINS;
        else        pins_prev <= pins_s;
    end

    always_comb begin
        set_vec = '0;
        set_vec[FLD_PIN_LSB +: PIN_W]   = (pins_s ^ pins_prev) & PIN_TOGGLE_MASK;
        set_vec[FLD_PIN_LSB + PIN_CD2]  = det_event;
        set_vec[FLD_PIN_LSB + PIN_CD1]  = det_event;
        set_vec[FLD_RDY_RISE] =  pins_s[PIN_RDY] & ~pins_prev[PIN_RDY];
        set_vec[FLD_RDY_FALL] = ~pins_s[PIN_RDY] &  pins_prev[PIN_RDY];
    end

    // write-one-to-clear, with a new set taking priority over the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= ((chg_q & ~clr) | set_vec) & STORE_MASK;
    end

    always_comb begin
        chg_view               = chg_q;
        chg_view[FLD_RDY_LOW]  = ~pins_s[PIN_RDY];
        chg_view[FLD_RDY_HIGH] =  pins_s[PIN_RDY];
    end

    assign irq = |(chg_view & en);

    // R5: a cleared bit with no concurrent set reads zero afterwards
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((chg_q & $past(clr & ~set_vec)) == '0));

    // R5: a set bit is never lost to a concurrent clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_vec) & ~chg_q) == '0));

    // R7: the rising-edge bit appears only after ready was seen high
    a_r7_rise_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_q[FLD_RDY_RISE]) |-> $past(pins_s[PIN_RDY]));
endmodule

// File: rtl/card_status_unit.sv
module card_status_unit
    import csu_pkg::*;
#(
    parameter int SLOTS       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOTS*PIN_W-1:0]   card_pins,
    input  logic [1:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic [SLOTS-1:0]         bus_wstrb,
    input  logic [SLOTS*FIELD_W-1:0] bus_wdata,
    output logic [SLOTS*FIELD_W-1:0] bus_rdata,
    output logic                     irq,
    output logic [SLOTS-1:0]         card_present
);
    localparam int DATA_W = SLOTS * FIELD_W;
    localparam logic [SLOTS*PIN_W-1:0] RST_ALL = {SLOTS{PIN_IDLE}};

    logic [SLOTS*PIN_W-1:0] pins_s;
    logic [DATA_W-1:0]      pin_word, chg_word, en_word;
    logic [SLOTS-1:0]       slot_irq;
    reg_sel_t               sel;

    assign sel = reg_sel_t'(bus_addr);

    csu_sync #(
        .W       (SLOTS*PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (RST_ALL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (card_pins),
        .q     (pins_s)
    );

    // slot 0 owns the top half; each further slot sits FIELD_W bits lower
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int LSB = (SLOTS - 1 - s) * FIELD_W;
        logic [FIELD_W-1:0] en_q, clr;
        logic               wr_here;

        assign wr_here = bus_wr && bus_wstrb[s];
        assign clr     = (wr_here && sel == REG_CHANGE) ? bus_wdata[LSB +: FIELD_W] : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          en_q <= '0;
            else if (wr_here && sel == REG_ENABLE) en_q <= bus_wdata[LSB +: FIELD_W];
        end

        assign en_word[LSB +: FIELD_W]  = en_q;
        assign pin_word[LSB +: FIELD_W] = {pins_s[s*PIN_W +: PIN_W], {(FIELD_W-PIN_W){1'b0}}};

        csu_slot #(.RST_PINS(PIN_IDLE)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins_s   (pins_s[s*PIN_W +: PIN_W]),
            .clr      (clr),
            .en       (en_q),
            .chg_view (chg_word[LSB +: FIELD_W]),
            .present  (card_present[s]),
            .irq      (slot_irq[s])
        );
    end

    assign irq = |slot_irq;

    always_comb begin
        unique case (sel)
            REG_PINS:   bus_rdata = pin_word;
            REG_CHANGE: bus_rdata = chg_word;
            REG_ENABLE: bus_rdata = en_word;
            REG_SPARE:  bus_rdata = '0;
        endcase
    end

    // R10: with every enable bit clear the interrupt stays low
    a_r10_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en_word == '0) |-> !irq);
endmodule

// File: tb/tb_card_status_unit.sv
`timescale 1ns/1ps
module tb_card_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] card_pins;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic [1:0]  bus_wstrb;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [1:0]  card_present;

    always #2.5 clk = ~clk;

    card_status_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .card_pins    (card_pins),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wstrb    (bus_wstrb),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq          (irq),
        .card_present (card_present)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  mp   [2];
    logic [15:0] mchg [2];
    logic [15:0] men  [2];
    bit          mloaded [2];

    function automatic logic [15:0] view(int s);
        logic [15:0] v;
        v    = mchg[s];
        v[7] = ~mp[s][0];
        v[6] =  mp[s][0];
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_pins(int s, logic [7:0] np);
        logic [7:0] d;
        d = (np ^ mp[s]) & 8'hE7;
        mchg[s][15:8] = mchg[s][15:8] | d;
        if (np[0] && !mp[s][0]) mchg[s][5] = 1'b1;
        if (!np[0] && mp[s][0]) mchg[s][4] = 1'b1;
        if (np[4:3] == 2'b00 && !mloaded[s]) begin
            mchg[s][12] = 1'b1; mchg[s][11] = 1'b1; mloaded[s] = 1'b1;
        end else if (np[4:3] == 2'b11 && mloaded[s]) begin
            mchg[s][12] = 1'b1; mchg[s][11] = 1'b1; mloaded[s] = 1'b0;
        end
        mp[s] = np;
    endtask

    task automatic model_write(logic [1:0] a, logic [1:0] strb, logic [31:0] data);
        for (int s = 0; s < 2; s++) begin
            if (strb[s]) begin
                if (a == 2'd1) mchg[s] = mchg[s] & ~data[(1-s)*16 +: 16];
                if (a == 2'd2) men[s]  = data[(1-s)*16 +: 16];
            end
        end
    endtask

    task automatic drive_pins(int s, logic [7:0] np);
        @(negedge clk);
        card_pins[s*8 +: 8] = np;
        model_pins(s, np);
        repeat (4) @(posedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [1:0] strb, logic [31:0] data);
        @(negedge clk);
        bus_addr = a; bus_wstrb = strb; bus_wdata = data; bus_wr = 1'b1;
        model_write(a, strb, data);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_check(logic [1:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic check_all(string tag);
        logic [31:0] cw, ew;
        cw = {view(0), view(1)};
        ew = {men[0], men[1]};
        read_check(2'd0, {mp[0], 8'h00, mp[1], 8'h00}, {tag, " R2 pins"});
        read_check(2'd1, cw, {tag, " R4 change"});
        read_check(2'd2, ew, {tag, " R9 enable"});
        read_check(2'd3, 32'h0, {tag, " R11 spare"});
        check({tag, " R10 irq"}, {31'h0, irq}, {31'h0, |(cw & ew)});
        check({tag, " R6 present"}, {30'h0, card_present},
              {30'h0, (mp[1][4:3] == 2'b00), (mp[0][4:3] == 2'b00)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1: got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] np;
        void'($urandom(32'd1234));
        card_pins = {8'h18, 8'h18};
        bus_addr = 2'd0; bus_wr = 1'b0; bus_wstrb = 2'b00; bus_wdata = 32'h0;
        for (int s = 0; s < 2; s++) begin
            mp[s] = 8'h18; mchg[s] = 16'h0; men[s] = 16'h0; mloaded[s] = 1'b0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // R1 reset state
        check_all("R1 reset");

        // R3 R4 voltage sense on slot A, then slot B
        drive_pins(0, 8'hD8);
        check_all("R4 vs slotA");
        read_check(2'd0, {mp[0], 8'h00, mp[1], 8'h00}, "R3 vs field slotA");
        check("R3 vs bits 31:30", {30'h0, bus_rdata[31:30]}, 32'd3);
        drive_pins(1, 8'h58);
        read_check(2'd0, {mp[0], 8'h00, mp[1], 8'h00}, "R3 vs field slotB");
        check("R3 vs bits 15:14", {30'h0, bus_rdata[15:14]}, 32'd1);
        drive_pins(1, 8'h3E);
        check_all("R4 slotB wp bvd");

        // R5 clear only slot A half
        bus_write(2'd1, 2'b01, 32'hFFFF_FFFF);
        check_all("R5 clear half");
        bus_write(2'd1, 2'b10, 32'h0000_2000);
        check_all("R5 clear one bit");
        bus_write(2'd1, 2'b11, 32'hFFFF_FFFF);

        // R6 detect bounce and insertion
        drive_pins(0, 8'h08);
        check_all("R6 split no event");
        drive_pins(0, 8'h18);
        check_all("R6 bounce no event");
        drive_pins(0, 8'h00);
        check_all("R6 insert");
        bus_write(2'd1, 2'b11, 32'hFFFF_FFFF);
        drive_pins(0, 8'h10);
        check_all("R6 leaving split");
        drive_pins(0, 8'h00);
        check_all("R6 back loaded");
        drive_pins(0, 8'h18);
        check_all("R6 removal");

        // R7 R8 ready edges and levels
        bus_write(2'd1, 2'b11, 32'hFFFF_FFFF);
        drive_pins(1, 8'h19);
        check_all("R7 R8 rise");
        drive_pins(1, 8'h18);
        check_all("R7 R8 fall");
        bus_write(2'd1, 2'b11, 32'hFFFF_FFFF);
        check_all("R8 level survives write");

        // R9 R10 enable halves and interrupt
        bus_write(2'd2, 2'b10, 32'hAAAA_0080);
        check_all("R9 R10 enable slotB level");
        bus_write(2'd2, 2'b01, 32'h0800_5555);
        check_all("R9 enable slotA");
        drive_pins(0, 8'h00);
        check_all("R10 detect irq");
        bus_write(2'd2, 2'b11, 32'h0);
        check_all("R10 irq off");

        // R11 writes to pin and spare addresses
        bus_write(2'd0, 2'b11, 32'hFFFF_FFFF);
        bus_write(2'd3, 2'b11, 32'hFFFF_FFFF);
        check_all("R11 no effect");

        // R5 set in the same cycle as a clear
        bus_write(2'd1, 2'b11, 32'hFFFF_FFFF);
        np = mp[0] ^ 8'h20;
        @(negedge clk);
        card_pins[7:0] = np;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd1; bus_wstrb = 2'b11; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        model_write(2'd1, 2'b11, 32'hFFFF_FFFF);
        model_pins(0, np);
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (4) @(posedge clk);
        check_all("R5 set wins");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 3);
            if (op <= 1) begin
                drive_pins($urandom_range(0, 1), 8'($urandom));
            end else if (op == 2) begin
                bus_write(2'd1, 2'($urandom), $urandom);
            end else begin
                bus_write(2'($urandom), 2'($urandom), $urandom);
            end
            check_all("RND");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule